// File: doc/BRIEF.md
# Exception Priority and Vector Resolver

This block looks at every exception that can be pending in a small processor core. These are the reset request, the non-maskable interrupt, hard fault, the three configurable fault types (memory management, bus, usage), the supervisor call, the pendable service request, the system tick and up to 55 external interrupt lines. Each cycle it names the single most urgent one. It outputs the winner's exception number and the byte address of the matching slot in the vector table. A fetch unit placed behind it can then read the handler address from that slot.

Three exceptions have fixed ranks above everything else. Every other exception has a 3-bit priority, and a smaller value means more urgent. These priorities and the table base are loaded through one write port. That port carries an address, a data word, a write enable and a privilege flag. The table base can be moved to any 512-byte boundary in the lower gigabyte of the address space. Only privileged writes may move it.

Top module: `exc_vector_resolver`

## Requirements
- R1: Exception numbers are fixed: reset 1, NMI 2, hard fault 3, memory management 4, bus fault 5, usage fault 6, supervisor call 11, pendable service 14, system tick 15, external line n is 16+n. Numbers 0, 7 to 10, 12 and 13 are never reported while `exc_valid` is high.
- R2: `vec_addr` equals the table base plus 4 times `exc_num`. While nothing is pending, `exc_num` is 0 and `vec_addr` equals the base.
- R3: After reset, the table base is 0, every configurable priority is 0 and the outputs are all zero.
- R4: A write with `cfg_addr` = 0 and `cfg_priv` high loads the table base. The same write with `cfg_priv` low leaves the base unchanged.
- R5: A write to the table base clears bits [8:0] and [31:30] of the written data before storing it.
- R6: Reset beats NMI, NMI beats hard fault, and all three beat every configurable exception, whatever the priority values.
- R7: Among configurable exceptions, the one with the smaller priority value wins, whatever the exception numbers.
- R8: Among configurable exceptions with equal priority values, the lowest exception number wins.
- R9: A write with `cfg_addr` equal to a configurable exception's number stores `cfg_wdata[2:0]` as that exception's priority, whatever the privilege flag. Writes to any other non-zero address change nothing.
- R10: Outputs are registered. A request present at a rising edge is reflected right after that edge. `exc_valid` is low after an edge at which nothing was pending. A configuration write takes effect for the decision made at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_reset | input | 1 | Reset exception pending |
| req_nmi | input | 1 | Non-maskable interrupt pending |
| req_hardfault | input | 1 | Hard fault pending |
| req_sys | input | 6 | Configurable system exceptions pending: bit0 memory management, bit1 bus fault, bit2 usage fault, bit3 supervisor call, bit4 pendable service, bit5 system tick |
| req_irq | input | 55 | External interrupt lines pending, bit n is line n |
| cfg_we | input | 1 | Configuration write enable |
| cfg_priv | input | 1 | Write is privileged |
| cfg_addr | input | 7 | 0 selects the table base, otherwise an exception number |
| cfg_wdata | input | 32 | Write data |
| exc_valid | output | 1 | Some exception is pending |
| exc_num | output | 7 | Winning exception number |
| vec_addr | output | 32 | Address of the winner's vector-table slot |

## Verification
If a priority register holds a wrong value, the effect appears only when that exception competes against another exception. It then shows up at the ports as the wrong winner, one edge after both requests are present. The bench therefore stages pairs whose outcome turns on that one stored value. If the base register is wrong, every later `vec_addr` is wrong, including the idle value, so one idle cycle after each base write exposes it. Mistakes in the comparison or tie rule only show when several requests overlap. Long runs of random overlapping requests, with priorities changing mid-run, are checked against an independent ranking model.

// File: rtl/exc_res_pkg.sv
// Package: constants shared by the exception resolver.
// Assumes the standard fixed exception numbering, with external lines from 16 upward.
package exc_res_pkg;
    localparam int EXC_RESET     = 1;
    localparam int EXC_NMI       = 2;
    localparam int EXC_HARDFAULT = 3;
    localparam int EXC_MEMMANAGE = 4;
    localparam int EXC_BUSFAULT  = 5;
    localparam int EXC_USAGE     = 6;
    localparam int EXC_SVCALL    = 11;
    localparam int EXC_PENDSV    = 14;
    localparam int EXC_SYSTICK   = 15;
    localparam int IRQ_FIRST     = 16;
    localparam int FIXED_CNT     = 3;
    localparam int SYS_CNT       = 6;

    // True when exception number n carries a programmable priority.
    function automatic logic is_cfg(input int n, input int num_exc);
        return (n == EXC_MEMMANAGE) || (n == EXC_BUSFAULT) || (n == EXC_USAGE) ||
               (n == EXC_SVCALL) || (n == EXC_PENDSV) || (n == EXC_SYSTICK) ||
               ((n >= IRQ_FIRST) && (n < num_exc));
    endfunction
endpackage

// File: rtl/exc_cfg_regs.sv
// Configuration storage: one priority register per configurable exception and the table base.
// Assumes a single write port. Address 0 selects the base, which needs the privilege flag.
// Any other address is an exception number. Non-configurable numbers are ignored.
module exc_cfg_regs #(
    parameter int NUM_EXC = 71,
    parameter int PRIO_W  = 3,
    parameter int EXC_W   = 7,
    parameter int ADDR_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic                      priv,
    input  logic [EXC_W-1:0]          addr,
    input  logic [ADDR_W-1:0]         wdata,
    output logic [NUM_EXC*PRIO_W-1:0] prio_flat,
    output logic [ADDR_W-1:0]         base
);
    localparam int ALIGN_BITS = 9;
    localparam int TOP_CLR    = 2;
    localparam logic [ADDR_W-1:0] BASE_KEEP =
        {{TOP_CLR{1'b0}}, {(ADDR_W-TOP_CLR-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

    // Table base: privileged writes to address 0 only, masked to legal alignment and range.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base <= '0;
        else if (we && priv && (addr == '0))
            base <= wdata & BASE_KEEP;
    end

    for (genvar g = 0; g < NUM_EXC; g++) begin : g_slot
        if (exc_res_pkg::is_cfg(g, NUM_EXC)) begin : g_reg
            logic [PRIO_W-1:0] level;
            // Priority register for exception number g.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    level <= '0;
                else if (we && (addr == EXC_W'(g)))
                    level <= wdata[PRIO_W-1:0];
            end
            assign prio_flat[g*PRIO_W +: PRIO_W] = level;
        end else begin : g_fixed
            assign prio_flat[g*PRIO_W +: PRIO_W] = '0;
        end
    end

    // R4
    unpriv_base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !priv) |=> $stable(base));

    // R9
    noncfg_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr != '0) && !exc_res_pkg::is_cfg(int'(addr), NUM_EXC)) |=> $stable(prio_flat));
endmodule

// File: rtl/exc_arbiter.sv
// Combinational winner selection over all exception numbers.
// Assumes reserved numbers are never pending. Fixed exceptions take ranks 0..2.
// Configurable ones rank at 3 plus their priority. A strict compare during an ascending scan
// makes the lowest number win a tie.
module exc_arbiter #(
    parameter int NUM_EXC = 71,
    parameter int PRIO_W  = 3,
    parameter int EXC_W   = 7
) (
    input  logic [NUM_EXC-1:0]        pend,
    input  logic [NUM_EXC*PRIO_W-1:0] prio_flat,
    output logic                      found,
    output logic [EXC_W-1:0]          win
);
    localparam int KEY_W = PRIO_W + 1;

    logic [KEY_W-1:0] best_key;
    logic [KEY_W-1:0] key_v;

    // Scan every number, keeping the smallest rank seen so far.
    always_comb begin
        found    = 1'b0;
        win      = '0;
        best_key = '1;
        key_v    = '0;
        for (int i = 1; i < NUM_EXC; i++) begin
            if (i <= exc_res_pkg::FIXED_CNT)
                key_v = KEY_W'(i - 1);
            else
                key_v = KEY_W'(exc_res_pkg::FIXED_CNT) + KEY_W'(prio_flat[i*PRIO_W +: PRIO_W]);
            if (pend[i] && (!found || (key_v < best_key))) begin
                found    = 1'b1;
                best_key = key_v;
                win      = EXC_W'(i);
            end
        end
    end

    // R1: a reported winner must actually be pending
    always_comb begin
        if (found) begin
            win_pending_chk: assert (pend[win]);
        end
    end
endmodule

// File: rtl/exc_vector_resolver.sv
// Top: maps the request pins onto exception numbers, picks a winner and registers
// its number and vector slot address. Assumes requests are synchronous to clk.
module exc_vector_resolver #(
    parameter int NUM_IRQ = 55,
    parameter int PRIO_W  = 3
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        req_reset,
    input  logic                                        req_nmi,
    input  logic                                        req_hardfault,
    input  logic [exc_res_pkg::SYS_CNT-1:0]             req_sys,
    input  logic [NUM_IRQ-1:0]                          req_irq,
    input  logic                                        cfg_we,
    input  logic                                        cfg_priv,
    input  logic [$clog2(exc_res_pkg::IRQ_FIRST+NUM_IRQ)-1:0] cfg_addr,
    input  logic [31:0]                                 cfg_wdata,
    output logic                                        exc_valid,
    output logic [$clog2(exc_res_pkg::IRQ_FIRST+NUM_IRQ)-1:0] exc_num,
    output logic [31:0]                                 vec_addr
);
    import exc_res_pkg::*;

    localparam int NUM_EXC = IRQ_FIRST + NUM_IRQ;
    localparam int EXC_W   = $clog2(NUM_EXC);
    localparam int ADDR_W  = 32;

    logic [NUM_EXC-1:0]        pend;
    logic [NUM_EXC*PRIO_W-1:0] prio_flat;
    logic [ADDR_W-1:0]         base;
    logic                      found;
    logic [EXC_W-1:0]          win;

    // Place each request pin at its exception number. Reserved numbers stay low.
    always_comb begin
        pend                              = '0;
        pend[EXC_RESET]                   = req_reset;
        pend[EXC_NMI]                     = req_nmi;
        pend[EXC_HARDFAULT]               = req_hardfault;
        pend[EXC_MEMMANAGE]               = req_sys[0];
        pend[EXC_BUSFAULT]                = req_sys[1];
        pend[EXC_USAGE]                   = req_sys[2];
        pend[EXC_SVCALL]                  = req_sys[3];
        pend[EXC_PENDSV]                  = req_sys[4];
        pend[EXC_SYSTICK]                 = req_sys[5];
        pend[NUM_EXC-1:IRQ_FIRST]         = req_irq;
    end

    exc_cfg_regs #(
        .NUM_EXC(NUM_EXC), .PRIO_W(PRIO_W), .EXC_W(EXC_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .priv(cfg_priv), .addr(cfg_addr),
        .wdata(cfg_wdata), .prio_flat(prio_flat), .base(base)
    );

    exc_arbiter #(
        .NUM_EXC(NUM_EXC), .PRIO_W(PRIO_W), .EXC_W(EXC_W)
    ) u_arb (
        .pend(pend), .prio_flat(prio_flat), .found(found), .win(win)
    );

    // Output stage: register the winner and its slot address (base + 4 * number).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_valid <= 1'b0;
            exc_num   <= '0;
            vec_addr  <= '0;
        end else begin
            exc_valid <= found;
            exc_num   <= found ? win : '0;
            vec_addr  <= base + (ADDR_W'(found ? win : '0) << 2);
        end
    end

    // R6
    reset_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_reset |=> (exc_valid && (exc_num == EXC_W'(EXC_RESET))));

    // R6
    nmi_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_nmi && !req_reset) |=> (exc_valid && (exc_num == EXC_W'(EXC_NMI))));

    // R10
    idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |=> !exc_valid);

    // R1
    reserved_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> !(exc_num inside {EXC_W'(0), EXC_W'(7), EXC_W'(8), EXC_W'(9),
                                        EXC_W'(10), EXC_W'(12), EXC_W'(13)}));

    // R2
    vec_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (vec_addr[EXC_W+1:0] == {exc_num, 2'b00}));
endmodule

// File: tb/exc_vector_resolver_tb.sv
module exc_vector_resolver_tb;
    localparam int NIRQ = 55;
    localparam int NEXC = 16 + NIRQ;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_reset = 1'b0, req_nmi = 1'b0, req_hardfault = 1'b0;
    logic [5:0]  req_sys = '0;
    logic [NIRQ-1:0] req_irq = '0;
    logic        cfg_we = 1'b0, cfg_priv = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        exc_valid;
    logic [6:0]  exc_num;
    logic [31:0] vec_addr;

    exc_vector_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .req_reset(req_reset), .req_nmi(req_nmi),
        .req_hardfault(req_hardfault), .req_sys(req_sys), .req_irq(req_irq),
        .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .exc_valid(exc_valid), .exc_num(exc_num), .vec_addr(vec_addr)
    );

    always #5 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // reference model state
    int          mprio [NEXC];
    logic [31:0] mbase;

    int          q_stamp [$];
    logic [39:0] q_exp [$];
    string       q_tag [$];

    function automatic bit cfg_ok(int n);
        return (n == 4 || n == 5 || n == 6 || n == 11 || n == 14 || n == 15 ||
                (n >= 16 && n < NEXC));
    endfunction

    // ranking model: fixed ranks first, then priority levels 0..7 in ascending number order
    function automatic logic [39:0] model(logic [NEXC-1:0] pv);
        int w = 0;
        if (pv[1]) w = 1;
        else if (pv[2]) w = 2;
        else if (pv[3]) w = 3;
        else begin
            for (int p = 0; p < 8 && w == 0; p++)
                for (int n = 4; n < NEXC && w == 0; n++)
                    if (pv[n] && cfg_ok(n) && mprio[n] == p) w = n;
        end
        return {(w != 0), 7'(w), mbase + 32'(4 * w)};
    endfunction

    function automatic logic [NEXC-1:0] bit_of(int n);
        logic [NEXC-1:0] v = '0;
        v[n] = 1'b1;
        return v;
    endfunction

    task automatic push(logic [NEXC-1:0] pv, string tag);
        q_stamp.push_back(cyc);
        q_exp.push_back(model(pv));
        q_tag.push_back(tag);
    endtask

    // driver: one cycle of requests
    task automatic drive(logic [NEXC-1:0] pv, string tag);
        @(negedge clk);
        cfg_we        = 1'b0;
        req_reset     = pv[1];
        req_nmi       = pv[2];
        req_hardfault = pv[3];
        req_sys       = {pv[15], pv[14], pv[11], pv[6], pv[5], pv[4]};
        req_irq       = pv[NEXC-1:16];
        push(pv, tag);
    endtask

    // driver: one configuration write cycle with no requests
    task automatic wr(int addr, logic [31:0] data, logic priv, string tag);
        @(negedge clk);
        {req_reset, req_nmi, req_hardfault} = '0;
        req_sys   = '0;
        req_irq   = '0;
        cfg_we    = 1'b1;
        cfg_priv  = priv;
        cfg_addr  = 7'(addr);
        cfg_wdata = data;
        push('0, tag);
        if (addr == 0) begin
            if (priv) mbase = data & 32'h3FFF_FE00;
        end else if (cfg_ok(addr)) begin
            mprio[addr] = int'(data[2:0]);
        end
    endtask

    // monitor: pop and compare once the design has had one edge
    always @(negedge clk) begin
        if (rst_n && q_stamp.size() > 0 && q_stamp[0] < cyc) begin
            logic [39:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            void'(q_stamp.pop_front());
            tests++;
            if ({exc_valid, exc_num, vec_addr} !== e) begin
                fails++;
                $display("FAIL %s: got v=%0d num=%0d addr=%h, exp v=%0d num=%0d addr=%h",
                         t, exc_valid, exc_num, vec_addr, e[39], e[38:32], e[31:0]);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout, exp completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int n = 0; n < NEXC; n++) mprio[n] = 0;
        mbase = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R3: outputs cleared by reset
        tests++;
        if ({exc_valid, exc_num, vec_addr} !== 40'd0) begin
            fails++;
            $display("FAIL R3 reset outputs: got %h, exp 0", {exc_valid, exc_num, vec_addr});
        end
        drive(bit_of(17) | bit_of(16), "R3 default priorities tie");
        drive(bit_of(16), "R1 R2 IRQ0 slot 0x40");
        drive(bit_of(15), "R1 R2 system tick slot 0x3C");
        drive(bit_of(70), "R1 R2 last line slot 0x118");
        drive(bit_of(4), "R1 memory management");
        drive(bit_of(11), "R1 supervisor call");
        drive(bit_of(14), "R1 pendable service");
        drive('0, "R10 idle after pulse");
        drive(bit_of(1) | bit_of(2) | bit_of(3) | bit_of(16), "R6 reset first");
        drive(bit_of(2) | bit_of(3) | bit_of(4), "R6 NMI second");
        drive(bit_of(3) | bit_of(5) | bit_of(70), "R6 hard fault third");
        drive(bit_of(16) | bit_of(11) | bit_of(6), "R8 tie lowest number");
        wr(16, 32'd5, 1'b0, "R9 write IRQ0 level");
        wr(17, 32'd2, 1'b1, "R9 write IRQ1 level");
        drive(bit_of(16) | bit_of(17), "R7 smaller value wins");
        wr(6, 32'd7, 1'b1, "R9 write usage level");
        drive(bit_of(6) | bit_of(70), "R7 line beats usage fault");
        wr(16, 32'h0000_0008, 1'b1, "R9 only low bits kept");
        drive(bit_of(16) | bit_of(17), "R9 IRQ0 back to level 0");
        wr(7, 32'd6, 1'b1, "R9 reserved address write");
        wr(2, 32'd6, 1'b1, "R9 NMI address write");
        drive(bit_of(16) | bit_of(17) | bit_of(2), "R9 ignored writes no effect");
        wr(0, 32'h2000_0412, 1'b1, "R5 base write");
        drive('0, "R2 idle shows base");
        drive(bit_of(16), "R4 R5 relocated IRQ0");
        wr(0, 32'h1000_0000, 1'b0, "R4 unprivileged base write");
        drive(bit_of(16), "R4 base unchanged");
        wr(0, 32'hFFFF_FFFF, 1'b1, "R5 base clamp");
        drive(bit_of(70), "R5 clamped base plus 0x118");
        for (int k = 0; k < 400; k++) begin
            logic [NEXC-1:0] pv = '0;
            if (k % 8 == 0) begin
                int a = 4 + int'($urandom % (NEXC - 4));
                wr(a, $urandom, $urandom % 2 == 0, "R9 random level write");
            end
            for (int n = 4; n < NEXC; n++)
                if (cfg_ok(n) && ($urandom % 10 == 0)) pv[n] = 1'b1;
            for (int n = 1; n <= 3; n++)
                if ($urandom % 30 == 0) pv[n] = 1'b1;
            drive(pv, "R8 random mix");
        end
        drive('0, "R10 final idle");
        while (q_stamp.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule